// File: doc/BRIEF.md
# Serial Channel Receive/Transmit FIFO Pair with Threshold Requests

This block holds the buffering for one serial channel: a receive queue filled by the deserializer and emptied by host reads, and a transmit queue filled by host writes and emptied by the serializer. Both queues are 16 entries deep. Each entry carries a data byte and a frame-boundary mark. On the receive side the mark flags an end-of-frame byte. On the transmit side it flags the last byte of a frame. The host reaches each queue through one data port: a read strobe for the receive side and a write strobe for the transmit side.

A single programmable threshold paces both directions. The receive side asks for service when enough bytes are waiting. In synchronous framing it also asks as soon as a complete frame sits in the queue. The transmit side asks for data when enough slots are free, or when the queue has drained. One routing bit steers both requests to either the interrupt outputs or the DMA burst outputs. In synchronous framing the transmit side goes quiet after the host has loaded a frame's last byte. It stays quiet until the serializer reports that the frame has left the line.

Top module: `chan_fifo_pair`

## Requirements
- R1: Each queue holds at most 16 entries. `rx_count` and `tx_count` show the occupancy one cycle after the strobe edge. A push to a full receive queue is dropped. When a push and a pop arrive in the same cycle, each is judged against the occupancy before that edge.
- R2: The effective threshold is `thr_cfg` when `thr_cfg` is 12 or less, and 12 for any larger `thr_cfg`.
- R3: With `sync_mode` = 0, the receive request is high exactly when `rx_count` is strictly greater than the effective threshold, or when `rx_timeout` is high.
- R4: With `sync_mode` = 1, the receive request is also high while at least one stored receive entry carries the end-of-frame mark. It falls once no marked entry remains and the count is at or below the threshold.
- R5: `rx_timeout` = 1 forces the receive request high in the same cycle, in either mode.
- R6: Outside a hold, the transmit request is high when `tx_empty_en` = 1 and `tx_count` = 0, or when `tx_more_en` = 1 and (16 − `tx_count`) is strictly greater than the threshold. With both enables at 0 the request stays low.
- R7: With `sync_mode` = 1, an accepted host write with `host_wr_last` = 1 holds the transmit request low from the next cycle on. A `tx_frame_sent` pulse ends the hold. If a new last-byte write lands in the same cycle as the pulse, the hold continues. Leaving sync mode also ends the hold.
- R8: With `dma_mode` = 0, the requests appear on `rx_irq` and `tx_irq`. With `dma_mode` = 1, they appear on `rx_dma_req` and `tx_dma_req`. The pair that is not selected stays at 0.
- R9: A host write while the transmit queue is full is dropped, and it sets `tx_overflow`. The flag stays set until reset.
- R10: A host read while the receive queue is empty returns data 0 with the end-of-frame flag at 0. It sets `rx_underflow`, which stays set until reset.
- R11: `host_rd_data`/`host_rd_eof` and `tx_pop_data`/`tx_pop_last` are registered. They take the head entry, in arrival order and with its mark bit, on the edge of the strobe. They hold that value until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_push | input | 1 | Deserializer delivers a byte |
| rx_push_data | input | 8 | Received byte |
| rx_push_eof | input | 1 | Received byte ends a frame |
| rx_timeout | input | 1 | Receive timeout, ORed into the receive request |
| host_rd | input | 1 | Host reads the receive data port |
| host_rd_data | output | 8 | Byte returned to the host |
| host_rd_eof | output | 1 | Returned byte ended a frame |
| host_wr | input | 1 | Host writes the transmit data port |
| host_wr_data | input | 8 | Byte written by the host |
| host_wr_last | input | 1 | Written byte is the last of a frame |
| tx_pop | input | 1 | Serializer takes a byte |
| tx_pop_data | output | 8 | Byte handed to the serializer |
| tx_pop_last | output | 1 | Handed byte is the last of a frame |
| tx_frame_sent | input | 1 | Serializer finished sending a frame |
| thr_cfg | input | 4 | Shared threshold setting |
| tx_empty_en | input | 1 | Enable the transmit request on an empty queue |
| tx_more_en | input | 1 | Enable the transmit request on the threshold |
| sync_mode | input | 1 | 1 = synchronous framing, 0 = asynchronous |
| dma_mode | input | 1 | 1 = route requests to DMA, 0 = to interrupts |
| rx_irq | output | 1 | Receive interrupt request |
| rx_dma_req | output | 1 | Receive DMA burst request |
| tx_irq | output | 1 | Transmit interrupt request |
| tx_dma_req | output | 1 | Transmit DMA burst request |
| rx_count | output | 5 | Receive occupancy |
| tx_count | output | 5 | Transmit occupancy |
| tx_overflow | output | 1 | Sticky: a host write was dropped |
| rx_underflow | output | 1 | Sticky: a host read found the queue empty |

## Verification
Occupancies, sticky flags, returned bytes and the transmit hold all come from registers, so each one is due exactly one clock edge after the strobe that caused it. The request outputs are combinational functions of those registers and of the live threshold, mode and timeout inputs. A timeout therefore shows in the same cycle it is driven, and a count change moves the requests one edge later. The bench drives inputs just after each falling edge. Its behavioural model updates at the rising edge. The bench compares every output at the next falling edge, before it drives anything new, so each result is sampled in the cycle it is due.

// File: rtl/chan_fifo_pkg.sv
package chan_fifo_pkg;

    localparam int unsigned FIFO_DEPTH = 16;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned THR_LIMIT  = 12;
    localparam int unsigned THR_W      = 4;

    // One queue entry: a data byte plus a frame-boundary mark.
    typedef struct packed {
        logic              mark;
        logic [DATA_W-1:0] data;
    } fifo_word_t;

    // Where the threshold-driven requests are delivered.
    typedef enum logic {
        ROUTE_IRQ = 1'b0,
        ROUTE_DMA = 1'b1
    } req_route_e;

    // Saturate a programmed threshold to the legal ceiling.
    function automatic int unsigned clamp_thr(input int unsigned raw,
                                              input int unsigned lim);
        return (raw > lim) ? lim : raw;
    endfunction

endpackage

// File: rtl/cf_store.sv
module cf_store #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 9,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic             push_ok, pop_ok;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];
    assign count   = cnt_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    p_count_cap_r1: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    p_full_drop_r1: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (count == CNT_W'(DEPTH)));

endmodule

// File: rtl/cf_rx_req.sv
module cf_rx_req #(
    parameter int unsigned CNT_W = 5,
    parameter int unsigned THR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic [THR_W-1:0] thr,
    input  logic             sync_mode,
    input  logic             mark_in,
    input  logic             mark_out,
    input  logic             timeout,
    output logic             req
);

    // Number of stored entries that close a frame.
    logic [CNT_W-1:0] eof_cnt;
    logic             level_hit, frame_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            eof_cnt <= '0;
        end else begin
            case ({mark_in, mark_out})
                2'b10:   eof_cnt <= eof_cnt + 1'b1;
                2'b01:   eof_cnt <= eof_cnt - 1'b1;
                default: eof_cnt <= eof_cnt;
            endcase
        end
    end

    assign level_hit = (count > CNT_W'(thr));
    assign frame_hit = sync_mode && (eof_cnt != '0);
    assign req       = level_hit || frame_hit || timeout;

    // Marked entries can never outnumber stored entries.
    p_eof_within_r4: assert property (@(posedge clk) disable iff (rst)
        eof_cnt <= count);

    // A freshly stored end-of-frame byte raises the sync request next cycle.
    p_eof_raises_r4: assert property (@(posedge clk) disable iff (rst)
        (mark_in && !mark_out && sync_mode) |=> (!sync_mode || req));

endmodule

// File: rtl/cf_tx_req.sv
module cf_tx_req #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = 5,
    parameter int unsigned THR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic [THR_W-1:0] thr,
    input  logic             sync_mode,
    input  logic             empty_en,
    input  logic             more_en,
    input  logic             last_loaded,
    input  logic             frame_sent,
    output logic             req
);

    logic             hold;
    logic [CNT_W-1:0] free_slots;
    logic             empty_hit, room_hit;

    always_ff @(posedge clk) begin
        if (rst) hold <= 1'b0;
        else     hold <= sync_mode && ((sync_mode && last_loaded) || (hold && !frame_sent));
    end

    assign free_slots = CNT_W'(DEPTH) - count;
    assign empty_hit  = empty_en && (count == '0);
    assign room_hit   = more_en && (free_slots > CNT_W'(thr));
    assign req        = !hold && (empty_hit || room_hit);

    p_hold_set_r7: assert property (@(posedge clk) disable iff (rst)
        (sync_mode && last_loaded) |=> !req);

    p_hold_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (hold && sync_mode && !frame_sent) |=> (!sync_mode || !req));

endmodule

// File: rtl/chan_fifo_pair.sv
module chan_fifo_pair
    import chan_fifo_pkg::*;
#(
    parameter int unsigned DEPTH     = FIFO_DEPTH,
    parameter int unsigned THR_MAX   = THR_LIMIT,
    localparam int unsigned CNT_W    = $clog2(DEPTH + 1),
    localparam int unsigned WORD_W   = $bits(fifo_word_t)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_push_data,
    input  logic              rx_push_eof,
    input  logic              rx_timeout,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rd_data,
    output logic              host_rd_eof,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wr_data,
    input  logic              host_wr_last,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_pop_data,
    output logic              tx_pop_last,
    input  logic              tx_frame_sent,
    input  logic [THR_W-1:0]  thr_cfg,
    input  logic              tx_empty_en,
    input  logic              tx_more_en,
    input  logic              sync_mode,
    input  logic              dma_mode,
    output logic              rx_irq,
    output logic              rx_dma_req,
    output logic              tx_irq,
    output logic              tx_dma_req,
    output logic [CNT_W-1:0]  rx_count,
    output logic [CNT_W-1:0]  tx_count,
    output logic              tx_overflow,
    output logic              rx_underflow
);

    fifo_word_t       rx_in, rx_head, tx_in, tx_head;
    logic             rx_full, rx_empty, tx_full, tx_empty;
    logic             rx_push_ok, rx_pop_ok, tx_wr_ok;
    logic [THR_W-1:0] thr_eff;
    logic             rx_req, tx_req;
    req_route_e       route;
    fifo_word_t       rd_q, txo_q;
    logic             ovf_q, udf_q;

    assign thr_eff = THR_W'(clamp_thr(int'(thr_cfg), THR_MAX));
    assign route   = req_route_e'(dma_mode);

    assign rx_in      = '{mark: rx_push_eof, data: rx_push_data};
    assign tx_in      = '{mark: host_wr_last, data: host_wr_data};
    assign rx_push_ok = rx_push && !rx_full;
    assign rx_pop_ok  = host_rd && !rx_empty;
    assign tx_wr_ok   = host_wr && !tx_full;

    cf_store #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_rx_store (
        .clk(clk), .rst(rst),
        .push(rx_push), .wdata(rx_in),
        .pop(host_rd), .head(rx_head),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    cf_store #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_tx_store (
        .clk(clk), .rst(rst),
        .push(host_wr), .wdata(tx_in),
        .pop(tx_pop), .head(tx_head),
        .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    cf_rx_req #(.CNT_W(CNT_W), .THR_W(THR_W)) u_rx_req (
        .clk(clk), .rst(rst),
        .count(rx_count), .thr(thr_eff), .sync_mode(sync_mode),
        .mark_in(rx_push_ok && rx_push_eof),
        .mark_out(rx_pop_ok && rx_head.mark),
        .timeout(rx_timeout), .req(rx_req)
    );

    cf_tx_req #(.DEPTH(DEPTH), .CNT_W(CNT_W), .THR_W(THR_W)) u_tx_req (
        .clk(clk), .rst(rst),
        .count(tx_count), .thr(thr_eff), .sync_mode(sync_mode),
        .empty_en(tx_empty_en), .more_en(tx_more_en),
        .last_loaded(tx_wr_ok && host_wr_last),
        .frame_sent(tx_frame_sent), .req(tx_req)
    );

    // Registered data ports and sticky error flags.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            txo_q <= '0;
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
        end else begin
            if (host_rd) rd_q  <= rx_empty ? '0 : rx_head;
            if (tx_pop)  txo_q <= tx_empty ? '0 : tx_head;
            if (host_wr && tx_full)  ovf_q <= 1'b1;
            if (host_rd && rx_empty) udf_q <= 1'b1;
        end
    end

    assign host_rd_data = rd_q.data;
    assign host_rd_eof  = rd_q.mark;
    assign tx_pop_data  = txo_q.data;
    assign tx_pop_last  = txo_q.mark;
    assign tx_overflow  = ovf_q;
    assign rx_underflow = udf_q;

    // Request routing: the selected pair carries the requests.
    always_comb begin
        rx_irq     = 1'b0;
        rx_dma_req = 1'b0;
        tx_irq     = 1'b0;
        tx_dma_req = 1'b0;
        if (route == ROUTE_DMA) begin
            rx_dma_req = rx_req;
            tx_dma_req = tx_req;
        end else begin
            rx_irq = rx_req;
            tx_irq = tx_req;
        end
    end

    p_route_split_r8: assert property (@(posedge clk) disable iff (rst)
        !((rx_irq || tx_irq) && (rx_dma_req || tx_dma_req)));

    p_async_level_r3: assert property (@(posedge clk) disable iff (rst)
        (!sync_mode && !rx_timeout && rx_count > 5'(thr_eff)) |-> (rx_irq || rx_dma_req));

    p_timeout_r5: assert property (@(posedge clk) disable iff (rst)
        rx_timeout |-> (rx_irq || rx_dma_req));

    p_thr_cap_r2: assert property (@(posedge clk) disable iff (rst)
        thr_eff <= THR_W'(THR_MAX));

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        tx_overflow |=> tx_overflow);

    p_udf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        rx_underflow |=> rx_underflow);

    p_udf_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (host_rd && rx_count == '0) |=> (host_rd_data == '0 && !host_rd_eof));

endmodule

// File: tb/chan_fifo_pair_tb.sv
module chan_fifo_pair_tb;
    import chan_fifo_pkg::*;

    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       rx_push = 0, rx_push_eof = 0, rx_timeout = 0, host_rd = 0;
    logic [7:0] rx_push_data = 0, host_wr_data = 0;
    logic       host_wr = 0, host_wr_last = 0, tx_pop = 0, tx_frame_sent = 0;
    logic [3:0] thr_cfg = 0;
    logic       tx_empty_en = 0, tx_more_en = 0, sync_mode = 0, dma_mode = 0;
    logic [7:0] host_rd_data, tx_pop_data;
    logic       host_rd_eof, tx_pop_last;
    logic       rx_irq, rx_dma_req, tx_irq, tx_dma_req, tx_overflow, rx_underflow;
    logic [CW-1:0] rx_count, tx_count;

    chan_fifo_pair u_dut (
        .clk(clk), .rst(rst),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_push_eof(rx_push_eof),
        .rx_timeout(rx_timeout),
        .host_rd(host_rd), .host_rd_data(host_rd_data), .host_rd_eof(host_rd_eof),
        .host_wr(host_wr), .host_wr_data(host_wr_data), .host_wr_last(host_wr_last),
        .tx_pop(tx_pop), .tx_pop_data(tx_pop_data), .tx_pop_last(tx_pop_last),
        .tx_frame_sent(tx_frame_sent), .thr_cfg(thr_cfg),
        .tx_empty_en(tx_empty_en), .tx_more_en(tx_more_en),
        .sync_mode(sync_mode), .dma_mode(dma_mode),
        .rx_irq(rx_irq), .rx_dma_req(rx_dma_req), .tx_irq(tx_irq), .tx_dma_req(tx_dma_req),
        .rx_count(rx_count), .tx_count(tx_count),
        .tx_overflow(tx_overflow), .rx_underflow(rx_underflow)
    );

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    // Behavioural reference state.
    logic [8:0] mrx[$];
    logic [8:0] mtx[$];
    bit         m_hold, m_ovf, m_udf;
    logic [8:0] m_rd, m_txo;
    bit         pre_rx_full, pre_rx_empty, pre_tx_full, pre_tx_empty, set_hold;

    always @(posedge clk) begin
        if (rst) begin
            mrx.delete(); mtx.delete();
            m_hold = 0; m_ovf = 0; m_udf = 0; m_rd = 0; m_txo = 0;
        end else begin
            pre_rx_full  = (mrx.size() == 16);
            pre_rx_empty = (mrx.size() == 0);
            pre_tx_full  = (mtx.size() == 16);
            pre_tx_empty = (mtx.size() == 0);
            set_hold     = 0;
            if (host_rd) begin
                if (pre_rx_empty) begin m_rd = 0; m_udf = 1; end
                else m_rd = mrx.pop_front();
            end
            if (rx_push && !pre_rx_full) mrx.push_back({rx_push_eof, rx_push_data});
            if (tx_pop) begin
                if (pre_tx_empty) m_txo = 0;
                else m_txo = mtx.pop_front();
            end
            if (host_wr) begin
                if (pre_tx_full) m_ovf = 1;
                else begin
                    mtx.push_back({host_wr_last, host_wr_data});
                    if (host_wr_last) set_hold = 1;
                end
            end
            m_hold = sync_mode && ((sync_mode && set_hold) || (m_hold && !tx_frame_sent));
        end
    end

    task automatic chk(input string req, input string nm,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, nm, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int  th;
        bit  eof_any, rq, tq;
        th = (thr_cfg > 12) ? 12 : int'(thr_cfg);       // R2 saturation
        eof_any = 0;
        foreach (mrx[i]) if (mrx[i][8]) eof_any = 1;
        rq = (mrx.size() > th) || (sync_mode && eof_any) || rx_timeout;
        tq = !m_hold && ((tx_empty_en && mtx.size() == 0) ||
                         (tx_more_en && (16 - mtx.size()) > th));
        chk("R1", "rx_count", 32'(rx_count), 32'(mrx.size()));
        chk("R1", "tx_count", 32'(tx_count), 32'(mtx.size()));
        chk("R3 R4 R5", "rx_request", 32'(rx_irq | rx_dma_req), 32'(rq));
        chk("R6 R7", "tx_request", 32'(tx_irq | tx_dma_req), 32'(tq));
        chk("R8", "irq_pair", {30'd0, rx_irq, tx_irq},
            dma_mode ? 32'd0 : {30'd0, rq, tq});
        chk("R8", "dma_pair", {30'd0, rx_dma_req, tx_dma_req},
            dma_mode ? {30'd0, rq, tq} : 32'd0);
        chk("R9", "tx_overflow", 32'(tx_overflow), 32'(m_ovf));
        chk("R10", "rx_underflow", 32'(rx_underflow), 32'(m_udf));
        chk("R11", "host_rd", {23'd0, host_rd_eof, host_rd_data}, 32'(m_rd));
        chk("R11", "tx_pop", {23'd0, tx_pop_last, tx_pop_data}, 32'(m_txo));
    endtask

    task automatic cyc();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        rx_push = 0; rx_push_eof = 0; host_rd = 0; host_wr = 0; host_wr_last = 0;
        tx_pop = 0; tx_frame_sent = 0; rx_timeout = 0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        @(posedge clk); @(negedge clk);
        cyc();                     // reset state (R1, R9, R10, R11)
        rst = 0;
        cyc();

        // R1 R2 R3: async fill past full with an oversize threshold.
        thr_cfg = 4'd15; tx_empty_en = 1; tx_more_en = 1;
        for (int i = 0; i < 18; i++) begin
            rx_push = 1; rx_push_data = 8'(8'h10 + i); rx_push_eof = (i == 5);
            cyc();
        end
        idle(); cyc();
        // R2: thresholds at and below the ceiling.
        for (int t = 0; t < 16; t++) begin thr_cfg = 4'(t); cyc(); end
        thr_cfg = 4'd3;
        // R11 R10: drain in order, then read past empty.
        for (int i = 0; i < 18; i++) begin host_rd = 1; cyc(); end
        idle(); cyc();

        // R4: sync framing, end-of-frame byte below threshold.
        sync_mode = 1; thr_cfg = 4'd8;
        rx_push = 1; rx_push_data = 8'hA1; cyc();
        rx_push_data = 8'hA2; rx_push_eof = 1; cyc();
        idle(); cyc(); cyc();
        host_rd = 1; cyc(); cyc();
        idle(); cyc();
        // R5: timeout pulse in both modes.
        rx_timeout = 1; cyc(); rx_timeout = 0; cyc();
        sync_mode = 0; rx_timeout = 1; cyc(); idle(); cyc();

        // R6 R9: fill transmit queue past full, sweep enables.
        thr_cfg = 4'd4;
        for (int i = 0; i < 18; i++) begin
            host_wr = 1; host_wr_data = 8'(8'h40 + i); cyc();
        end
        idle(); cyc();
        for (int e = 0; e < 4; e++) begin
            tx_empty_en = e[0]; tx_more_en = e[1];
            for (int i = 0; i < 17; i++) begin tx_pop = 1; cyc(); end
            tx_pop = 0; cyc();
            for (int i = 0; i < 6; i++) begin host_wr = 1; host_wr_data = 8'(i); cyc(); end
            host_wr = 0; cyc();
        end

        // R7: sync hold after a frame's last byte, released by frame sent.
        tx_empty_en = 1; tx_more_en = 1; sync_mode = 1;
        for (int i = 0; i < 8; i++) begin tx_pop = 1; cyc(); end
        idle();
        host_wr = 1; host_wr_data = 8'h77; cyc();
        host_wr_last = 1; host_wr_data = 8'h78; cyc();
        idle(); cyc();
        for (int i = 0; i < 3; i++) begin tx_pop = 1; cyc(); end
        idle(); cyc(); cyc();
        tx_frame_sent = 1; host_wr = 1; host_wr_last = 1; cyc();
        idle(); cyc();
        tx_frame_sent = 1; cyc(); idle(); cyc();

        // R8: route requests to DMA and back.
        dma_mode = 1; rx_push = 1; for (int i = 0; i < 6; i++) cyc();
        idle(); cyc(); dma_mode = 0; cyc();

        // Mixed traffic across every mode.
        for (int i = 0; i < 3000; i++) begin
            rx_push       = ($urandom % 3) != 0;
            rx_push_data  = 8'($urandom);
            rx_push_eof   = ($urandom % 5) == 0;
            host_rd       = ($urandom % 3) == 0;
            host_wr       = ($urandom % 2) == 0;
            host_wr_data  = 8'($urandom);
            host_wr_last  = ($urandom % 6) == 0;
            tx_pop        = ($urandom % 2) == 0;
            tx_frame_sent = ($urandom % 9) == 0;
            rx_timeout    = ($urandom % 40) == 0;
            if ((i % 97) == 0) begin
                thr_cfg = 4'($urandom); sync_mode = 1'($urandom);
                dma_mode = 1'($urandom);
                tx_empty_en = 1'($urandom); tx_more_en = 1'($urandom);
            end
            cyc();
        end
        idle(); cyc();

        done = 1;
        summary();
        $finish;
    end

endmodule